// File: doc/BRIEF.md
# Misaligned Transfer Cycle Splitter

The splitter accepts one load or store at a time from a core: a byte address, an operand size and, for stores, a 32-bit operand. It breaks the access into a short series of cycles on a 16-bit data bus. Each cycle presents an even word address, two active-low lane enables and, for stores, the operand bytes placed on the lanes they belong to. For loads, the lanes returned in each cycle are gathered into an operand assembly register.

An operand that crosses a word boundary takes two or three cycles. These cycles follow a fixed order. First come the words in the next 4-byte group, in ascending order. Then come the words in the starting group, also ascending. As a result, the lowest byte of a misaligned operand moves last. The splitter holds a cycle on the bus until the acknowledge input is sampled high. One clock after the final acknowledge it pulses done, and for a load it presents the assembled operand at that time.

Top module: `mts_splitter`

## Requirements
- R1: After reset, bus_valid_o and done_o are low, req_ready_o is high, and bus_be_no is 2'b11.
- R2: Size code 0 is a byte and takes one cycle. Its word address is the even address at or below the byte address. Only its lane enable is low: bus_be_no[1] for odd addresses (lane bits 15:8) and bus_be_no[0] for even addresses (lane bits 7:0). Size code 1 is a word; at an even address it takes one cycle with bus_be_no = 2'b00. Every word address put on the bus is even.
- R3: For a word at G+1, where G is a multiple of 4, the cycles are (G, be 2'b01) then (G+2, be 2'b10). For a word at G+3 they are (G+4, be 2'b10) then (G+2, be 2'b01).
- R4: Size code 2 is a doubleword; size code 3 is treated the same. At G+1 it takes (G+4, 2'b10), then (G, 2'b01), then (G+2, 2'b00).
- R5: A doubleword at G takes (G, 2'b00) then (G+2, 2'b00). At G+2 it takes (G+4, 2'b00) then (G+2, 2'b00).
- R6: A doubleword at G+3 takes (G+4, 2'b00), then (G+6, 2'b10), then (G+2, 2'b01). These carry operand bytes 2:1 on lanes 15:0, then byte 3 on lane 7:0, then byte 0 on lane 15:8.
- R7: In every store cycle, an enabled lane carries the operand byte whose byte address equals the word address plus the lane number (0 for 7:0, 1 for 15:8). A disabled lane reads zero. bus_we_o follows the request's write flag.
- R8: For a load, in the cycle where done_o is high, rdata_o holds, for each k below the operand length, the byte returned for address A+k at operand byte k. All bytes above the operand length are zero.
- R9: A cycle keeps its address, enables and data unchanged, and stays valid, until bus_ack_i is sampled high with bus_valid_o.
- R10: done_o is high for exactly one clock, starting in the clock after the last cycle is acknowledged. req_ready_o is low whenever a cycle is on the bus, and a new request is accepted only while req_ready_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Splitter idle, request taken on this edge |
| req_we_i | input | 1 | 1 = store, 0 = load |
| req_size_i | input | 2 | 0 byte, 1 word, 2 or 3 doubleword |
| req_addr_i | input | AW | Byte address of the operand |
| req_wdata_i | input | 32 | Store operand, byte 0 in bits 7:0 |
| bus_valid_o | output | 1 | Cycle on the bus |
| bus_we_o | output | 1 | Cycle is a write |
| bus_addr_o | output | AW | Word address, always even |
| bus_be_no | output | 2 | Lane enables, active low; bit 1 = lane 15:8, bit 0 = lane 7:0 |
| bus_wdata_o | output | 16 | Steered store lanes |
| bus_rdata_i | input | 16 | Returned load lanes |
| bus_ack_i | input | 1 | Current cycle complete |
| done_o | output | 1 | Operand complete, one-clock pulse |
| rdata_o | output | 32 | Assembled load operand |

## Verification
The hardest cases to reach combine the three-cycle doubleword orders with acknowledges that arrive at irregular times. In these cases the lowest byte lands last and must join bytes gathered several clocks earlier. The stimulus sweeps all sizes and all four address offsets for both loads and stores. Acknowledges are mostly random, and a forced run of withheld acknowledges is placed on a three-cycle operand. The bench also issues each new request in the same clock as the previous done pulse, so the assembled operand is checked while the next access is already being accepted.

// File: rtl/mts_pkg.sv
package mts_pkg;
  localparam int LANES    = 2;
  localparam int OP_BYTES = 4;

  typedef struct packed {
    logic [2:0] off;   // word offset from the 4-byte group base
    logic [1:0] en;    // active-high lane enables, bit1 = upper lane
    logic       last;
  } cyc_t;

  function automatic cyc_t mk_cyc(logic [2:0] off, logic [1:0] en, logic last);
    cyc_t c;
    c.off  = off;
    c.en   = en;
    c.last = last;
    return c;
  endfunction
endpackage

// File: rtl/mts_plan.sv
module mts_plan
  import mts_pkg::*;
(
  input  logic [1:0] size_i,
  input  logic [1:0] lo_i,
  input  logic [1:0] idx_i,
  output cyc_t       cyc_o
);
  always_comb begin
    cyc_o = mk_cyc(3'd0, 2'b00, 1'b1);
    unique case (size_i)
      2'd0: cyc_o = mk_cyc({1'b0, lo_i[1], 1'b0}, lo_i[0] ? 2'b10 : 2'b01, 1'b1);
      2'd1: begin
        unique case (lo_i)
          2'd0: cyc_o = mk_cyc(3'd0, 2'b11, 1'b1);
          2'd2: cyc_o = mk_cyc(3'd2, 2'b11, 1'b1);
          2'd1: cyc_o = (idx_i == 2'd0) ? mk_cyc(3'd0, 2'b10, 1'b0)
                                        : mk_cyc(3'd2, 2'b01, 1'b1);
          default: cyc_o = (idx_i == 2'd0) ? mk_cyc(3'd4, 2'b01, 1'b0)
                                           : mk_cyc(3'd2, 2'b10, 1'b1);
        endcase
      end
      default: begin
        // upper group first, lowest byte last
        unique case (lo_i)
          2'd0: cyc_o = (idx_i == 2'd0) ? mk_cyc(3'd0, 2'b11, 1'b0)
                                        : mk_cyc(3'd2, 2'b11, 1'b1);
          2'd1: begin
            if (idx_i == 2'd0)      cyc_o = mk_cyc(3'd4, 2'b01, 1'b0);
            else if (idx_i == 2'd1) cyc_o = mk_cyc(3'd0, 2'b10, 1'b0);
            else                    cyc_o = mk_cyc(3'd2, 2'b11, 1'b1);
          end
          2'd2: cyc_o = (idx_i == 2'd0) ? mk_cyc(3'd4, 2'b11, 1'b0)
                                        : mk_cyc(3'd2, 2'b11, 1'b1);
          default: begin
            if (idx_i == 2'd0)      cyc_o = mk_cyc(3'd4, 2'b11, 1'b0);
            else if (idx_i == 2'd1) cyc_o = mk_cyc(3'd6, 2'b01, 1'b0);
            else                    cyc_o = mk_cyc(3'd2, 2'b10, 1'b1);
          end
        endcase
      end
    endcase
  end
endmodule

// File: rtl/mts_lanes.sv
module mts_lanes
  import mts_pkg::*;
(
  input  logic [2:0]                off_i,
  input  logic [LANES-1:0]          en_i,
  input  logic [1:0]                lo_i,
  input  logic [8*OP_BYTES-1:0]     wdata_i,
  output logic [8*LANES-1:0]        wdata_o,
  output logic [LANES-1:0][1:0]     byte_idx_o
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [2:0] k;
    // operand byte = word offset + lane - start offset
    assign k             = off_i + 3'(g) - {1'b0, lo_i};
    assign byte_idx_o[g] = k[1:0];
    assign wdata_o[8*g +: 8] = en_i[g] ? wdata_i[8*k[1:0] +: 8] : 8'h00;
  end
endmodule

// File: rtl/mts_splitter.sv
module mts_splitter
  import mts_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic          req_we_i,
  input  logic [1:0]    req_size_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [31:0]   req_wdata_i,
  output logic          bus_valid_o,
  output logic          bus_we_o,
  output logic [AW-1:0] bus_addr_o,
  output logic [1:0]    bus_be_no,
  output logic [15:0]   bus_wdata_o,
  input  logic [15:0]   bus_rdata_i,
  input  logic          bus_ack_i,
  output logic          done_o,
  output logic [31:0]   rdata_o
);
  localparam int OPW = 8 * OP_BYTES;

  logic              busy_q, we_q, done_q;
  logic [1:0]        idx_q, size_q;
  logic [AW-1:0]     addr_q;
  logic [OPW-1:0]    wdata_q, asm_q;
  cyc_t              cyc;
  logic [15:0]       lane_w;
  logic [LANES-1:0][1:0] lane_idx;

  mts_plan u_plan (
    .size_i (size_q),
    .lo_i   (addr_q[1:0]),
    .idx_i  (idx_q),
    .cyc_o  (cyc)
  );

  mts_lanes u_lanes (
    .off_i      (cyc.off),
    .en_i       (cyc.en),
    .lo_i       (addr_q[1:0]),
    .wdata_i    (wdata_q),
    .wdata_o    (lane_w),
    .byte_idx_o (lane_idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      we_q    <= 1'b0;
      done_q  <= 1'b0;
      idx_q   <= '0;
      size_q  <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      asm_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (req_valid_i) begin
          busy_q  <= 1'b1;
          idx_q   <= '0;
          we_q    <= req_we_i;
          size_q  <= (req_size_i == 2'd3) ? 2'd2 : req_size_i;
          addr_q  <= req_addr_i;
          wdata_q <= req_wdata_i;
          asm_q   <= '0;
        end
      end else if (bus_ack_i) begin
        if (!we_q) begin
          for (int g = 0; g < LANES; g++) begin
            if (cyc.en[g]) asm_q[8*lane_idx[g] +: 8] <= bus_rdata_i[8*g +: 8];
          end
        end
        if (cyc.last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          idx_q <= idx_q + 2'd1;
        end
      end
    end
  end

  assign req_ready_o = !busy_q;
  assign bus_valid_o = busy_q;
  assign bus_we_o    = busy_q && we_q;
  assign bus_addr_o  = {addr_q[AW-1:2], 2'b00} + AW'(cyc.off);
  assign bus_be_no   = busy_q ? ~cyc.en : 2'b11;
  assign bus_wdata_o = (busy_q && we_q) ? lane_w : 16'h0000;
  assign done_o      = done_q;
  assign rdata_o     = asm_q;

  p_be_active_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_valid_o |-> bus_be_no != 2'b11);
  p_even_addr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_valid_o |-> !bus_addr_o[0]);
  p_lane_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_valid_o && bus_we_o && bus_be_no[0]) |-> bus_wdata_o[7:0] == 8'h00);
  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_valid_o && !bus_ack_i) |=> (bus_valid_o && $stable(bus_addr_o)
                                     && $stable(bus_be_no) && $stable(bus_wdata_o)));
  p_done_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_done_after_ack_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(bus_valid_o && bus_ack_i));
  p_busy_not_ready_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_valid_o |-> !req_ready_o);
endmodule

// File: tb/mts_splitter_test.sv
module mts_splitter_test;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_we = 1'b0;
  logic [1:0]  req_size = '0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic        bus_valid, bus_we, req_ready, done;
  logic [31:0] bus_addr, rdata;
  logic [1:0]  bus_be_n;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata = '0;
  logic        bus_ack = 1'b0;

  int n_chk = 0, n_fail = 0;
  int stall = 0;

  logic [31:0] q_addr[$];
  logic [1:0]  q_be[$];
  logic [15:0] q_wd[$];
  bit          q_last[$];
  string       q_tag[$];
  bit          r_we[$];
  logic [31:0] r_data[$];

  bit          exp_done = 0, exp_rd = 0;
  logic [31:0] exp_rdata = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mts_splitter #(.AW(32)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_we_i(req_we),
    .req_size_i(req_size), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .bus_valid_o(bus_valid), .bus_we_o(bus_we), .bus_addr_o(bus_addr),
    .bus_be_no(bus_be_n), .bus_wdata_o(bus_wdata), .bus_rdata_i(bus_rdata),
    .bus_ack_i(bus_ack), .done_o(done), .rdata_o(rdata)
  );

  function automatic logic [7:0] mem_byte(logic [31:0] a);
    return 8'((a * 37) + 11);
  endfunction

  task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // monitor and acknowledge driver, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk(done == exp_done, "R10", "done", 32'(done), 32'(exp_done));
      if (exp_done && exp_rd) chk(rdata == exp_rdata, "R8", "rdata", rdata, exp_rdata);
      exp_done = 0;
      bus_ack  = 1'b0;
      if (bus_valid) begin
        if (q_addr.size() == 0) begin
          chk(0, "R10", "unexpected cycle", bus_addr, 32'hffffffff);
        end else begin
          string t;
          t = (stall > 0) ? "R9" : q_tag[0];
          chk(bus_addr == q_addr[0], t, "addr", bus_addr, q_addr[0]);
          chk(bus_be_n == q_be[0], t, "be_n", 32'(bus_be_n), 32'(q_be[0]));
          chk(bus_we == r_we[0], "R7", "we", 32'(bus_we), 32'(r_we[0]));
          if (r_we[0]) chk(bus_wdata == q_wd[0], "R7", "wdata", 32'(bus_wdata), 32'(q_wd[0]));
          chk(!req_ready, "R10", "ready while busy", 32'(req_ready), 32'd0);
          if (stall > 0) stall--;
          else bus_ack = ($urandom % 4) != 0;
          bus_rdata = {mem_byte(bus_addr + 1), mem_byte(bus_addr)};
          if (bus_ack) begin
            if (q_last[0]) begin
              exp_done  = 1;
              exp_rd    = !r_we[0];
              exp_rdata = r_data[0];
              void'(r_we.pop_front());
              void'(r_data.pop_front());
            end
            void'(q_addr.pop_front());
            void'(q_be.pop_front());
            void'(q_wd.pop_front());
            void'(q_last.pop_front());
            void'(q_tag.pop_front());
          end
        end
      end
    end
  end

  task automatic issue(bit we, logic [1:0] sz, logic [31:0] a, logic [31:0] wd, int hold);
    int n;
    logic [31:0] g, w0, w1;
    logic [31:0] words[$];
    logic [31:0] ord[$];
    logic [31:0] rd;
    string tag;
    n = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    g = a & ~32'd3;
    if (sz == 0 || (sz == 1 && !a[0])) tag = "R2";
    else if (sz == 1) tag = "R3";
    else if (a[1:0] == 1) tag = "R4";
    else if (a[1:0] == 3) tag = "R6";
    else tag = "R5";
    w0 = a & ~32'd1;
    w1 = (a + n - 1) & ~32'd1;
    for (logic [31:0] w = w0; w <= w1; w += 2) words.push_back(w);
    foreach (words[i]) if (words[i] >= g + 4) ord.push_back(words[i]);
    foreach (words[i]) if (words[i] < g + 4) ord.push_back(words[i]);
    rd = '0;
    for (int k = 0; k < n; k++) rd[8*k +: 8] = mem_byte(a + k);
    do begin
      @(posedge clk); #1;
    end while (!req_ready || q_addr.size() != 0);
    foreach (ord[i]) begin
      logic [1:0]  be;
      logic [15:0] wd16;
      be = 2'b11;
      wd16 = '0;
      for (int l = 0; l < 2; l++) begin
        logic [31:0] b;
        b = ord[i] + l;
        if (b >= a && b < a + n) begin
          be[l] = 1'b0;
          wd16[8*l +: 8] = wd[8*(b - a) +: 8];
        end
      end
      q_addr.push_back(ord[i]);
      q_be.push_back(be);
      q_wd.push_back(wd16);
      q_last.push_back(i == ord.size() - 1);
      q_tag.push_back(tag);
    end
    r_we.push_back(we);
    r_data.push_back(rd);
    stall = hold;
    req_valid = 1'b1; req_we = we; req_size = sz; req_addr = a; req_wdata = wd;
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(!bus_valid && !done && req_ready && bus_be_n == 2'b11, "R1", "reset state",
        {bus_valid, done, req_ready, bus_be_n}, {3'b001, 2'b11});
    // R6 under a forced run of withheld acknowledges (R9)
    issue(1'b0, 2'd2, 32'h0000_0103, 32'h0, 6);
    issue(1'b1, 2'd2, 32'h0000_0201, 32'hA1B2C3D4, 4);
    for (int rep = 0; rep < 3; rep++) begin
      for (int sz = 0; sz < 4; sz++) begin
        for (int lo = 0; lo < 4; lo++) begin
          logic [31:0] base;
          base = (rep == 0) ? 32'h40 : (rep == 1) ? 32'h1234_5670 : 32'h0000_0ff8;
          issue(1'b1, 2'(sz), base + lo, $urandom, 0);
          issue(1'b0, 2'(sz), base + lo, $urandom, 0);
        end
      end
    end
    do @(posedge clk); while (q_addr.size() != 0);
    repeat (4) @(posedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R10 watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule